// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the register file of a 16-bit processor core. Seven general registers exist in two full copies (banks): four data registers D0 to D3, two address registers AD0 and AD1, and a frame base register. A bank-select flag picks the copy that all accesses reach. A set of unbanked registers sits beside the banks and is the same whichever bank is active. These are the user stack pointer, the interrupt stack pointer, the static base and a 20-bit interrupt vector base held as a 16-bit low field and a 4-bit high field.

There is one write port and one read port. Each port takes a 4-bit register specifier and a 2-bit access size: byte, word or 32-bit pair. Reads are combinational from the current state. Writes are committed at the rising clock edge. A small flag port sets the bank-select and stack-select flags. Any request that names a register with no such access is reported as illegal on that port, and it changes nothing.

Top module: `dual_bank_regfile`

## Requirements
- R1: On reset, bank 0 and the user stack pointer are selected, and every banked and shared register reads zero.
- R2: Word access (size 1) uses these specifiers: 0-3 for D0-D3, 4 and 5 for AD0 and AD1, 6 for the frame base, 7 for the user SP, 8 for the interrupt SP, 9 for the static base, 10 for the vector-base low field and 11 for its high field. A word read returns the value in rd_data[15:0], with the upper bits zero.
- R3: Byte access (size 0) uses specifier 0 for the D0 low byte, 1 for the D0 high byte, 2 for the D1 low byte and 3 for the D1 high byte. A byte write takes wr_data[7:0] and leaves the other byte of the register unchanged. A byte read is zero-extended.
- R4: A request is illegal, raises wr_illegal or rd_illegal and writes nothing in these cases: byte access with a specifier of 4 or more, pair access with a specifier of 3 or more, size 3, or word access with a specifier of 13 or more. An illegal read returns zero.
- R5: Pair access (size 2) uses specifier 0 for D2:D0, 1 for D3:D1 and 2 for AD1:AD0, with the first-named register in bits 31:16. A pair write updates both registers in the same cycle.
- R6: A flag write takes effect from the next cycle. A write in the same cycle as a flag change still goes to the bank that was active. The inactive bank keeps its contents.
- R7: The shared registers read the same value whichever bank is active.
- R8: The high field of the vector base stores wr_data[3:0] and reads back zero-extended. Its low field is an independent 16-bit register.
- R9: Word specifier 12 reaches the active stack pointer: the user SP when the stack-select flag is 0 and the interrupt SP when it is 1. sp_o always shows the active stack pointer.
- R10: A read in the same cycle as a write to the same register returns the old value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_spec | input | 4 | Write register specifier |
| wr_size | input | 2 | Write access size: 0 byte, 1 word, 2 pair |
| wr_data | input | 32 | Write data |
| wr_illegal | output | 1 | The current write request is illegal |
| rd_spec | input | 4 | Read register specifier |
| rd_size | input | 2 | Read access size |
| rd_data | output | 32 | Read data, zero-extended |
| rd_illegal | output | 1 | The current read request is illegal |
| flag_we | input | 1 | Flag write strobe |
| flag_bank | input | 1 | New bank-select value |
| flag_spsel | input | 1 | New stack-select value |
| bank_o | output | 1 | Active bank |
| spsel_o | output | 1 | Active stack pointer select |
| sp_o | output | 16 | Active stack pointer value |

## Verification
rd_data, rd_illegal and wr_illegal are combinational, so each one is due in the same cycle as the request that causes it. A write, or a flag change, shows up only one rising edge later. The bench therefore drives each request at the falling edge and checks the combinational results 1 ns later, before the next rising edge. Effects of a write are checked by a read driven at the following falling edge. Directed cases place a write and a flag change in the same cycle, and a read and a write to the same register in the same cycle, to pin down that one-edge boundary.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = WORD_W / 2;
    localparam int DATA_W    = 2 * WORD_W;
    localparam int TBH_W     = 4;
    localparam int SPEC_W    = 4;
    localparam int SLOT_W    = 4;
    localparam int NSLOT     = 1 << SLOT_W;
    localparam int NUM_BANKS = 2;
    localparam int BANKED    = 7;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_PAIR = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    // unified storage slot numbering
    localparam logic [SLOT_W-1:0] SL_D0  = 4'd0;
    localparam logic [SLOT_W-1:0] SL_D1  = 4'd1;
    localparam logic [SLOT_W-1:0] SL_D2  = 4'd2;
    localparam logic [SLOT_W-1:0] SL_D3  = 4'd3;
    localparam logic [SLOT_W-1:0] SL_AD0 = 4'd4;
    localparam logic [SLOT_W-1:0] SL_AD1 = 4'd5;
    localparam logic [SLOT_W-1:0] SL_USP = 4'd7;
    localparam logic [SLOT_W-1:0] SL_ISP = 4'd8;
    localparam logic [SLOT_W-1:0] SL_SB  = 4'd9;
    localparam logic [SLOT_W-1:0] SL_TBL = 4'd10;
    localparam logic [SLOT_W-1:0] SL_TBH = 4'd11;
    localparam logic [SPEC_W-1:0] SPEC_SP = 4'd12;

    typedef struct packed {
        logic              legal;
        logic              pair;
        logic              is_byte;
        logic              byte_hi;
        logic [SLOT_W-1:0] lo_slot;
        logic [SLOT_W-1:0] hi_slot;
    } acc_dec_t;
endpackage

// File: rtl/rf_acc_decode.sv
module rf_acc_decode
    import dbrf_pkg::*;
(
    input  logic [SPEC_W-1:0] spec,
    input  logic [1:0]        size,
    input  logic              spsel,
    output acc_dec_t          dec
);
    always_comb begin
        dec = '0;
        unique case (acc_size_e'(size))
            ACC_BYTE: begin
                if (spec < 4'd4) begin
                    dec.legal   = 1'b1;
                    dec.is_byte = 1'b1;
                    dec.byte_hi = spec[0];
                    dec.lo_slot = spec[1] ? SL_D1 : SL_D0;
                end
            end
            ACC_WORD: begin
                if (spec <= SL_TBH) begin
                    dec.legal   = 1'b1;
                    dec.lo_slot = spec;
                end else if (spec == SPEC_SP) begin
                    dec.legal   = 1'b1;
                    dec.lo_slot = spsel ? SL_ISP : SL_USP;
                end
            end
            ACC_PAIR: begin
                dec.pair = 1'b1;
                case (spec)
                    4'd0: begin dec.legal = 1'b1; dec.lo_slot = SL_D0;  dec.hi_slot = SL_D2;  end
                    4'd1: begin dec.legal = 1'b1; dec.lo_slot = SL_D1;  dec.hi_slot = SL_D3;  end
                    4'd2: begin dec.legal = 1'b1; dec.lo_slot = SL_AD0; dec.hi_slot = SL_AD1; end
                    default: dec.pair = 1'b0;
                endcase
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import dbrf_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int NREG = BANKED
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_lo,
    input  logic [SLOT_W-1:0]          idx_lo,
    input  logic [W-1:0]               val_lo,
    input  logic                       we_hi,
    input  logic [SLOT_W-1:0]          idx_hi,
    input  logic [W-1:0]               val_hi,
    output logic [NREG-1:0][W-1:0]     regs_o
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] r;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (we_lo && idx_lo == SLOT_W'(i)) st_d.r[i] = val_lo;
            if (we_hi && idx_hi == SLOT_W'(i)) st_d.r[i] = val_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.r;
endmodule

// File: rtl/rf_shared.sv
module rf_shared
    import dbrf_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int HW = TBH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] idx,
    input  logic [W-1:0]      val,
    input  logic              flag_we,
    input  logic              flag_bank,
    input  logic              flag_spsel,
    output logic [W-1:0]      usp_o,
    output logic [W-1:0]      isp_o,
    output logic [W-1:0]      sb_o,
    output logic [W-1:0]      tbl_o,
    output logic [HW-1:0]     tbh_o,
    output logic              bank_o,
    output logic              spsel_o
);
    typedef struct packed {
        logic [W-1:0]  usp;
        logic [W-1:0]  isp;
        logic [W-1:0]  sb;
        logic [W-1:0]  tbl;
        logic [HW-1:0] tbh;
        logic          bank;
        logic          spsel;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (idx)
                SL_USP: st_d.usp = val;
                SL_ISP: st_d.isp = val;
                SL_SB:  st_d.sb  = val;
                SL_TBL: st_d.tbl = val;
                SL_TBH: st_d.tbh = val[HW-1:0];
                default: ;
            endcase
        end
        if (flag_we) begin
            st_d.bank  = flag_bank;
            st_d.spsel = flag_spsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign usp_o   = st_q.usp;
    assign isp_o   = st_q.isp;
    assign sb_o    = st_q.sb;
    assign tbl_o   = st_q.tbl;
    assign tbh_o   = st_q.tbh;
    assign bank_o  = st_q.bank;
    assign spsel_o = st_q.spsel;

    // R9
    spsel_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> spsel_o == $past(flag_spsel));
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
    import dbrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_spec,
    input  logic [1:0]        wr_size,
    input  logic [31:0]       wr_data,
    output logic              wr_illegal,
    input  logic [3:0]        rd_spec,
    input  logic [1:0]        rd_size,
    output logic [31:0]       rd_data,
    output logic              rd_illegal,
    input  logic              flag_we,
    input  logic              flag_bank,
    input  logic              flag_spsel,
    output logic              bank_o,
    output logic              spsel_o,
    output logic [15:0]       sp_o
);
    acc_dec_t wr_dec, rd_dec;
    logic     bank_q, spsel_q;

    logic [NUM_BANKS-1:0][BANKED-1:0][WORD_W-1:0] bank_regs;
    logic [WORD_W-1:0] usp_q, isp_q, sb_q, tbl_q;
    logic [TBH_W-1:0]  tbh_q;
    logic [NSLOT-1:0][WORD_W-1:0] slot_view;

    logic              wr_go;
    logic [WORD_W-1:0] cur_lo, wval_lo, wval_hi;
    logic              lo_banked;

    rf_acc_decode u_wr_dec (.spec(wr_spec), .size(wr_size), .spsel(spsel_q), .dec(wr_dec));
    rf_acc_decode u_rd_dec (.spec(rd_spec), .size(rd_size), .spsel(spsel_q), .dec(rd_dec));

    // flat view of every register as the active bank sees it
    always_comb begin
        slot_view = '0;
        for (int i = 0; i < BANKED; i++)
            slot_view[i] = bank_regs[bank_q][i];
        slot_view[SL_USP] = usp_q;
        slot_view[SL_ISP] = isp_q;
        slot_view[SL_SB]  = sb_q;
        slot_view[SL_TBL] = tbl_q;
        slot_view[SL_TBH] = {{(WORD_W-TBH_W){1'b0}}, tbh_q};
    end

    // write data shaping
    always_comb begin
        wr_go     = wr_en && wr_dec.legal;
        lo_banked = wr_dec.lo_slot < SLOT_W'(BANKED);
        cur_lo    = slot_view[wr_dec.lo_slot];
        wval_hi   = wr_data[DATA_W-1:WORD_W];
        if (wr_dec.is_byte)
            wval_lo = wr_dec.byte_hi ? {wr_data[BYTE_W-1:0], cur_lo[BYTE_W-1:0]}
                                     : {cur_lo[WORD_W-1:BYTE_W], wr_data[BYTE_W-1:0]};
        else
            wval_lo = wr_data[WORD_W-1:0];
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel_this;
        assign sel_this = wr_go && (bank_q == 1'(g));
        rf_bank #(.W(WORD_W), .NREG(BANKED)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_lo  (sel_this && lo_banked),
            .idx_lo (wr_dec.lo_slot),
            .val_lo (wval_lo),
            .we_hi  (sel_this && wr_dec.pair),
            .idx_hi (wr_dec.hi_slot),
            .val_hi (wval_hi),
            .regs_o (bank_regs[g])
        );
    end

    rf_shared #(.W(WORD_W), .HW(TBH_W)) u_shared (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (wr_go && !lo_banked),
        .idx        (wr_dec.lo_slot),
        .val        (wval_lo),
        .flag_we    (flag_we),
        .flag_bank  (flag_bank),
        .flag_spsel (flag_spsel),
        .usp_o      (usp_q),
        .isp_o      (isp_q),
        .sb_o       (sb_q),
        .tbl_o      (tbl_q),
        .tbh_o      (tbh_q),
        .bank_o     (bank_q),
        .spsel_o    (spsel_q)
    );

    // read path
    always_comb begin
        rd_data = '0;
        if (rd_dec.legal) begin
            if (rd_dec.is_byte)
                rd_data[BYTE_W-1:0] = rd_dec.byte_hi ? slot_view[rd_dec.lo_slot][WORD_W-1:BYTE_W]
                                                     : slot_view[rd_dec.lo_slot][BYTE_W-1:0];
            else if (rd_dec.pair)
                rd_data = {slot_view[rd_dec.hi_slot], slot_view[rd_dec.lo_slot]};
            else
                rd_data[WORD_W-1:0] = slot_view[rd_dec.lo_slot];
        end
    end

    assign rd_illegal = !rd_dec.legal;
    assign wr_illegal = wr_en && !wr_dec.legal;
    assign bank_o     = bank_q;
    assign spsel_o    = spsel_q;
    assign sp_o       = spsel_q ? isp_q : usp_q;

    // R4
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(bank_regs) && $stable({usp_q, isp_q, sb_q, tbl_q, tbh_q}));

    // R6
    idle_bank1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q == 1'b0) |=> $stable(bank_regs[1]));

    // R6
    idle_bank0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q == 1'b1) |=> $stable(bank_regs[0]));

    // R3
    byte_keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0 && wr_spec == 4'd0 && !bank_q)
        |=> bank_regs[0][0][WORD_W-1:BYTE_W] == $past(bank_regs[0][0][WORD_W-1:BYTE_W]));

    // R5
    pair_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd2 && wr_spec == 4'd0 && !bank_q)
        |=> bank_regs[0][2] == $past(wr_data[31:16]) && bank_regs[0][0] == $past(wr_data[15:0]));

    // R6
    bank_flag_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> bank_o == $past(flag_bank));
endmodule

// File: tb/dual_bank_regfile_bench.sv
module dual_bank_regfile_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_spec = '0;
    logic [1:0] wr_size = '0;
    logic [31:0] wr_data = '0;
    logic wr_illegal;
    logic [3:0] rd_spec = '0;
    logic [1:0] rd_size = 2'd1;
    logic [31:0] rd_data;
    logic rd_illegal;
    logic flag_we = 1'b0, flag_bank = 1'b0, flag_spsel = 1'b0;
    logic bank_o, spsel_o;
    logic [15:0] sp_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dual_bank_regfile u_dual_bank_regfile (.*);

    typedef struct packed {
        logic [1:0]  op;    // 0 read, 1 write, 2 flag
        logic [3:0]  spec;
        logic [1:0]  size;  // 0 byte, 1 word, 2 pair, 3 reserved
        logic [31:0] data;
        logic [31:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd0,  2'd1, 32'h0,        32'h0,        1'b0, 4'd1},  // R1
        '{2'd1, 4'd0,  2'd1, 32'h1234,     32'h0,        1'b0, 4'd2},  // R2
        '{2'd0, 4'd0,  2'd1, 32'h0,        32'h1234,     1'b0, 4'd2},
        '{2'd1, 4'd1,  2'd0, 32'hAB,       32'h0,        1'b0, 4'd3},  // R3
        '{2'd0, 4'd0,  2'd1, 32'h0,        32'hAB34,     1'b0, 4'd3},
        '{2'd0, 4'd0,  2'd0, 32'h0,        32'h34,       1'b0, 4'd3},
        '{2'd0, 4'd1,  2'd0, 32'h0,        32'hAB,       1'b0, 4'd3},
        '{2'd1, 4'd2,  2'd0, 32'h5A,       32'h0,        1'b0, 4'd3},
        '{2'd0, 4'd1,  2'd1, 32'h0,        32'h5A,       1'b0, 4'd3},
        '{2'd1, 4'd4,  2'd0, 32'hFF,       32'h0,        1'b1, 4'd4},  // R4
        '{2'd0, 4'd4,  2'd1, 32'h0,        32'h0,        1'b0, 4'd4},
        '{2'd0, 4'd6,  2'd0, 32'h0,        32'h0,        1'b1, 4'd4},
        '{2'd1, 4'd0,  2'd2, 32'h11112222, 32'h0,        1'b0, 4'd5},  // R5
        '{2'd0, 4'd2,  2'd1, 32'h0,        32'h1111,     1'b0, 4'd5},
        '{2'd0, 4'd0,  2'd2, 32'h0,        32'h11112222, 1'b0, 4'd5},
        '{2'd1, 4'd2,  2'd2, 32'hA1A1A0A0, 32'h0,        1'b0, 4'd5},
        '{2'd0, 4'd5,  2'd1, 32'h0,        32'hA1A1,     1'b0, 4'd5},
        '{2'd0, 4'd4,  2'd1, 32'h0,        32'hA0A0,     1'b0, 4'd5},
        '{2'd1, 4'd3,  2'd2, 32'h5555,     32'h0,        1'b1, 4'd4},
        '{2'd1, 4'd0,  2'd3, 32'h5555,     32'h0,        1'b1, 4'd4},
        '{2'd1, 4'd13, 2'd1, 32'h5555,     32'h0,        1'b1, 4'd4},
        '{2'd0, 4'd1,  2'd2, 32'h0,        32'h0000005A, 1'b0, 4'd5},
        '{2'd0, 4'd0,  2'd2, 32'h0,        32'h11112222, 1'b0, 4'd4},
        '{2'd1, 4'd9,  2'd1, 32'h5B5B,     32'h0,        1'b0, 4'd7},  // R7
        '{2'd1, 4'd10, 2'd1, 32'hCDEF,     32'h0,        1'b0, 4'd8},  // R8
        '{2'd1, 4'd11, 2'd1, 32'hFFF7,     32'h0,        1'b0, 4'd8},
        '{2'd0, 4'd11, 2'd1, 32'h0,        32'h7,        1'b0, 4'd8},
        '{2'd0, 4'd10, 2'd1, 32'h0,        32'hCDEF,     1'b0, 4'd8},
        '{2'd1, 4'd7,  2'd1, 32'h7777,     32'h0,        1'b0, 4'd9},  // R9
        '{2'd1, 4'd8,  2'd1, 32'h8888,     32'h0,        1'b0, 4'd9},
        '{2'd0, 4'd12, 2'd1, 32'h0,        32'h7777,     1'b0, 4'd9},
        '{2'd1, 4'd6,  2'd1, 32'hFBFB,     32'h0,        1'b0, 4'd2},
        '{2'd0, 4'd6,  2'd1, 32'h0,        32'hFBFB,     1'b0, 4'd2},
        '{2'd2, 4'd0,  2'd0, 32'h3,        32'h0,        1'b0, 4'd6},  // R6 bank 1, interrupt SP
        '{2'd0, 4'd0,  2'd1, 32'h0,        32'h0,        1'b0, 4'd6},
        '{2'd0, 4'd6,  2'd1, 32'h0,        32'h0,        1'b0, 4'd6},
        '{2'd0, 4'd12, 2'd1, 32'h0,        32'h8888,     1'b0, 4'd9},
        '{2'd0, 4'd9,  2'd1, 32'h0,        32'h5B5B,     1'b0, 4'd7},
        '{2'd0, 4'd10, 2'd1, 32'h0,        32'hCDEF,     1'b0, 4'd7},
        '{2'd1, 4'd0,  2'd1, 32'hBEEF,     32'h0,        1'b0, 4'd6},
        '{2'd1, 4'd12, 2'd1, 32'h1313,     32'h0,        1'b0, 4'd9},
        '{2'd0, 4'd8,  2'd1, 32'h0,        32'h1313,     1'b0, 4'd9},
        '{2'd2, 4'd0,  2'd0, 32'h0,        32'h0,        1'b0, 4'd6},
        '{2'd0, 4'd0,  2'd1, 32'h0,        32'h2222,     1'b0, 4'd6},
        '{2'd0, 4'd12, 2'd1, 32'h0,        32'h7777,     1'b0, 4'd9},
        '{2'd1, 4'd12, 2'd1, 32'h1212,     32'h0,        1'b0, 4'd9},
        '{2'd0, 4'd7,  2'd1, 32'h0,        32'h1212,     1'b0, 4'd9},
        '{2'd0, 4'd6,  2'd1, 32'h0,        32'hFBFB,     1'b0, 4'd6},
        '{2'd0, 4'd15, 2'd1, 32'h0,        32'h0,        1'b1, 4'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_word(input logic [3:0] s);
        rd_spec = s;
        rd_size = 2'd1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", {31'b0, bank_o}, 32'h0);
        chk("R1", {31'b0, spsel_o}, 32'h0);
        chk("R1", {16'b0, sp_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = 1'b0; flag_we = 1'b0;
            case (VECS[i].op)
                2'd0: begin rd_spec = VECS[i].spec; rd_size = VECS[i].size; end
                2'd1: begin wr_en = 1'b1; wr_spec = VECS[i].spec; wr_size = VECS[i].size;
                            wr_data = VECS[i].data; end
                default: begin flag_we = 1'b1; flag_bank = VECS[i].data[0];
                               flag_spsel = VECS[i].data[1]; end
            endcase
            #1;
            if (VECS[i].op == 2'd0) begin
                chk($sformatf("R%0d", VECS[i].req), rd_data, VECS[i].exp);
                chk($sformatf("R%0d", VECS[i].req), {31'b0, rd_illegal}, {31'b0, VECS[i].ill});
            end else if (VECS[i].op == 2'd1) begin
                chk($sformatf("R%0d", VECS[i].req), {31'b0, wr_illegal}, {31'b0, VECS[i].ill});
            end
            @(posedge clk);
            #1;
            if (VECS[i].op == 2'd2)
                chk("R6", {30'b0, spsel_o, bank_o}, {30'b0, VECS[i].data[1:0]});
            wr_en = 1'b0; flag_we = 1'b0;
        end

        // R10 and R6: write plus flag change in one cycle, read old value meanwhile
        @(negedge clk);
        flag_we = 1'b1; flag_bank = 1'b1; flag_spsel = 1'b0;
        wr_en = 1'b1; wr_spec = 4'd0; wr_size = 2'd1; wr_data = 32'h0F0F;
        rd_word(4'd0);
        #1;
        chk("R10", rd_data, 32'h2222);
        @(posedge clk); #1;
        wr_en = 1'b0; flag_we = 1'b0;
        chk("R6", rd_data, 32'hBEEF);   // bank 1 untouched by the write
        chk("R9", {16'b0, sp_o}, 32'h1212);
        @(negedge clk);
        flag_we = 1'b1; flag_bank = 1'b0;
        @(posedge clk); #1;
        flag_we = 1'b0;
        chk("R6", rd_data, 32'h0F0F);

        // R10 static base read during its own write
        @(negedge clk);
        wr_en = 1'b1; wr_spec = 4'd9; wr_size = 2'd1; wr_data = 32'h9999;
        rd_word(4'd9);
        #1;
        chk("R10", rd_data, 32'h5B5B);
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R10", rd_data, 32'h9999);

        // R1 reset in mid-run clears both banks and shared state
        @(negedge clk);
        flag_we = 1'b1; flag_bank = 1'b1; flag_spsel = 1'b1;
        @(posedge clk); #1;
        flag_we = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1", {30'b0, spsel_o, bank_o}, 32'h0);
        rd_word(4'd9); #1;
        chk("R1", rd_data, 32'h0);
        rd_word(4'd0); #1;
        chk("R1", rd_data, 32'h0);
        @(negedge clk);
        flag_we = 1'b1; flag_bank = 1'b1; flag_spsel = 1'b0;
        @(posedge clk); #1;
        flag_we = 1'b0;
        chk("R1", rd_data, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule